// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer with In-Order Readout

This block is the digital controller of a four-lane data acquisition front end in which every lane has its own track/hold stage feeding one shared successive-approximation converter. A rising edge on the convert-start input puts all lanes into hold at once. The controller then converts the programmed number of lanes one after another, always beginning at lane 0 (channel 1). Each conversion lasts a fixed number of clock cycles, and the controller captures each result word into a small four-word buffer. When the last lane is done, the lanes go back to tracking and an active-low interrupt is raised.

The host programs two settings: how many lanes a sample set contains, and whether the A or the B input of each lane's two-way multiplexer is sampled. The host reads results through a chip-select and read-strobe port. The buffer has no address. A pointer that wraps around presents the words in lane order, starting again at lane 0 after the last programmed lane. Convert-start edges are ignored while a sample set is being converted, and also until the minimum tracking (acquisition) time has passed since the lanes were released. The analog stages are not part of this block: the converter's result reaches it as a data word, and its only analog control outputs are the hold level and the A/B select.

States:
- ST_ACQUIRE: lanes tracking, acquisition timer running. Entered from reset and at the end of a sample set. It moves to ST_READY when the timer reaches the acquisition cycle count.
- ST_READY: lanes tracking, waiting for a convert-start edge. It moves to ST_CONVERT on that edge.
- ST_CONVERT: lanes held, converting one lane per conversion period. It advances to the next lane at the end of each period. After the last programmed lane it returns to ST_ACQUIRE.

Top module: `simsamp_seq`

## Requirements
- R1: After reset the outputs are as follows: `hold` is 0, `int_n` is 1 and `in_sel_b` is 0 (input set A). The read pointer is at lane 0 and every buffer word is 0, so `dout` reads 0 while `cs_n` is low. The lane count defaults to four (`cfg_last` = 3).
- R2: A 0-to-1 change of `conv_start`, seen while in ST_READY, raises `hold` in the next cycle. `hold` then stays high for exactly (`cfg_last`+1) × CONV_CYC cycles, where CONV_CYC = ceil(CLK_MHZ × CONV_NS / 1000), which is 375 at the defaults.
- R3: Rising edges of `conv_start` while `hold` is high are ignored. They neither lengthen the conversion nor start a second sample set.
- R4: During `hold`, `conv_lane` shows the lane being converted. It starts at 0, increases by 1 every CONV_CYC cycles, and ends at `cfg_last`. The `conv_data` word present in the final cycle of a lane's period is stored as that lane's result.
- R5: In the cycle in which `hold` falls, `int_n` falls to 0.
- R6: While `cs_n` is 0, `dout` shows the buffer word at the read pointer; while `cs_n` is 1, `dout` is 0. A read strobe is a 0-to-1 change of `rd_n` while `cs_n` is 0, and it moves the pointer to the next lane. Channel 1 (lane 0) is always the first word read.
- R7: A strobe made when the pointer is at lane `cfg_last` wraps the pointer back to lane 0, so further strobes cycle through the words again.
- R8: `cs_n` may stay low across any number of strobes. A 0-to-1 change of `rd_n` while `cs_n` is 1 does not move the pointer.
- R9: `int_n` returns to 1 on the first read strobe after it fell, and not when `rd_n` goes low.
- R10: After `hold` falls, a `conv_start` edge is ignored until ACQ_CYC = ceil(CLK_MHZ × ACQ_NS / 1000) cycles of tracking have passed (125 at the defaults). A start level already high when ST_READY is reached does not count as an edge.
- R11: `cfg_we` = 1 loads `cfg_last` (the lane count minus 1) and `cfg_sel_b` (1 selects input set B, shown on `in_sel_b`). A write is taken in any state except ST_CONVERT, and it is ignored while converting.
- R12: The end of every sample set returns the read pointer to lane 0, whatever position earlier reads left it at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_last | input | LW (2) | Number of lanes minus 1 |
| cfg_sel_b | input | 1 | Input-set select to program: 0 = A, 1 = B |
| conv_start | input | 1 | Convert start; its rising edge triggers a sample set |
| conv_data | input | RES_W (14) | Result word from the converter for the current lane |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe; its rising edge advances the pointer |
| hold | output | 1 | 1 = lanes in hold, 0 = lanes tracking |
| in_sel_b | output | 1 | Input multiplexer select applied to all lanes |
| conv_lane | output | LW (2) | Lane being converted |
| int_n | output | 1 | Active-low completion flag |
| dout | output | RES_W (14) | Word at the read pointer, or 0 while deselected |

## Verification
`hold` is due one cycle after the clock edge that samples the start edge, and it lasts (`cfg_last`+1) × 375 cycles. `int_n` falls in the same cycle that `hold` drops. Pointer moves and the `int_n` release appear one cycle after the edge that samples `rd_n` high after a low. The bench drives and samples on falling clock edges. It counts falling edges from the first hold-high sample, so the lane index expected at count k is k/375 and the measured hold length is compared with the formula. `dout` and its dependence on `cs_n` are combinational, so they are checked shortly after the input change within the same low phase. The sweep covers every lane count with both input sets, using converter words that the bench computes from a per-run tag, the lane and the select.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;

    typedef enum logic [1:0] {
        ST_ACQUIRE = 2'd0,
        ST_READY   = 2'd1,
        ST_CONVERT = 2'd2
    } seq_state_e;

    // Rounds a duration up to whole clock cycles.
    function automatic int unsigned ns_to_cycles(int unsigned mhz, int unsigned ns);
        return (mhz * ns + 999) / 1000;
    endfunction

endpackage

// File: rtl/simsamp_edge.sv
module simsamp_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic q;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign rise = d & ~q;
endmodule

// File: rtl/simsamp_timer.sv
module simsamp_timer #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/simsamp_rbuf.sv
module simsamp_rbuf #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 14,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          ptr_home,
    input  logic          rd_adv,
    input  logic [IW-1:0] last_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0]  words [DEPTH];
    logic [IW-1:0] ptr;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= '0;
            else if (wr_en && (wr_idx == IW'(i)))
                words[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (ptr_home)
            ptr <= '0;
        else if (rd_adv)
            ptr <= (ptr == last_idx) ? '0 : ptr + 1'b1;
    end

    assign rd_data = words[ptr];
endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq
    import simsamp_pkg::*;
#(
    parameter int unsigned LANES   = 4,
    parameter int unsigned RES_W   = 14,
    parameter int unsigned CLK_MHZ = 125,
    parameter int unsigned CONV_NS = 3000,
    parameter int unsigned ACQ_NS  = 1000,
    localparam int unsigned LW     = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [LW-1:0]    cfg_last,
    input  logic             cfg_sel_b,
    input  logic             conv_start,
    input  logic [RES_W-1:0] conv_data,
    input  logic             cs_n,
    input  logic             rd_n,
    output logic             hold,
    output logic             in_sel_b,
    output logic [LW-1:0]    conv_lane,
    output logic             int_n,
    output logic [RES_W-1:0] dout
);
    localparam int unsigned CONV_CYC = ns_to_cycles(CLK_MHZ, CONV_NS);
    localparam int unsigned ACQ_CYC  = ns_to_cycles(CLK_MHZ, ACQ_NS);
    localparam int unsigned TMR_MAX  = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
    localparam int unsigned TMR_W    = $clog2(TMR_MAX + 1);

    seq_state_e         state_q, state_d;
    logic [TMR_W-1:0]   tmr;
    logic               tmr_clr, tmr_en;
    logic               acq_done, conv_done;
    logic               start_edge, rd_rise, rd_strobe;
    logic [LW-1:0]      lane_q;
    logic [LW-1:0]      cfg_last_q;
    logic               sel_b_q;
    logic               int_n_q;
    logic               wr_en, seq_done;
    logic [RES_W-1:0]   rd_word;

    simsamp_edge #(.RST_VAL(1'b0)) u_start_edge (
        .clk(clk), .rst_n(rst_n), .d(conv_start), .rise(start_edge)
    );

    simsamp_edge #(.RST_VAL(1'b1)) u_rd_edge (
        .clk(clk), .rst_n(rst_n), .d(rd_n), .rise(rd_rise)
    );

    assign rd_strobe = rd_rise & ~cs_n;

    simsamp_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en), .cnt(tmr)
    );

    assign acq_done  = (tmr == TMR_W'(ACQ_CYC - 1));
    assign conv_done = (tmr == TMR_W'(CONV_CYC - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACQUIRE;
        else        state_q <= state_d;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE: if (acq_done) state_d = ST_READY;
            ST_READY:   if (start_edge) state_d = ST_CONVERT;
            ST_CONVERT: if (conv_done && (lane_q == cfg_last_q)) state_d = ST_ACQUIRE;
            default:    state_d = ST_ACQUIRE;
        endcase
    end

    // Outputs and strobes decoded from the state
    always_comb begin
        hold     = 1'b0;
        tmr_en   = 1'b0;
        wr_en    = 1'b0;
        seq_done = 1'b0;
        unique case (state_q)
            ST_ACQUIRE: tmr_en = 1'b1;
            ST_READY:   tmr_en = 1'b0;
            ST_CONVERT: begin
                hold     = 1'b1;
                tmr_en   = 1'b1;
                wr_en    = conv_done;
                seq_done = conv_done && (lane_q == cfg_last_q);
            end
            default: ;
        endcase
        tmr_clr = (state_d != state_q) || wr_en;
    end

    // Lane index
    always_ff @(posedge clk) begin
        if (!rst_n)
            lane_q <= '0;
        else if ((state_q == ST_READY) && start_edge)
            lane_q <= '0;
        else if (wr_en && !seq_done)
            lane_q <= lane_q + 1'b1;
    end

    // Programmed settings, frozen during conversion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_last_q <= LW'(LANES - 1);
            sel_b_q    <= 1'b0;
        end else if (cfg_we && (state_q != ST_CONVERT)) begin
            cfg_last_q <= cfg_last;
            sel_b_q    <= cfg_sel_b;
        end
    end

    // Completion flag
    always_ff @(posedge clk) begin
        if (!rst_n)         int_n_q <= 1'b1;
        else if (seq_done)  int_n_q <= 1'b0;
        else if (rd_strobe) int_n_q <= 1'b1;
    end

    simsamp_rbuf #(.DEPTH(LANES), .W(RES_W)) u_rbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (lane_q),
        .wr_data  (conv_data),
        .ptr_home (seq_done),
        .rd_adv   (rd_strobe),
        .last_idx (cfg_last_q),
        .rd_data  (rd_word)
    );

    assign conv_lane = lane_q;
    assign in_sel_b  = sel_b_q;
    assign int_n     = int_n_q;
    assign dout      = cs_n ? '0 : rd_word;
endmodule

// File: rtl/simsamp_seq_chk.sv
module simsamp_seq_chk #(
    parameter int unsigned CONV_CYC = 375,
    parameter int unsigned ACQ_CYC  = 125,
    parameter int unsigned LW       = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hold,
    input logic          int_n,
    input logic          in_sel_b,
    input logic [LW-1:0] conv_lane,
    input logic          cs_n,
    input logic          rd_n,
    input logic [LW-1:0] lanes_last
);
    int unsigned hld_cnt;
    int unsigned trk_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hld_cnt <= 0;
            trk_cnt <= 0;
        end else begin
            hld_cnt <= hold ? hld_cnt + 1 : 0;
            if (hold)                trk_cnt <= 0;
            else if (trk_cnt < ACQ_CYC) trk_cnt <= trk_cnt + 1;
        end
    end

    // R2, R3: hold length is set by the lane count alone
    p_hold_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> (hld_cnt == (int'(lanes_last) + 1) * CONV_CYC));

    p_first_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> (conv_lane == '0));

    p_lane_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold) && (conv_lane != $past(conv_lane)))
        |-> (conv_lane == LW'($past(conv_lane) + 1'b1)));

    p_int_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $fell(hold));

    p_int_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_n) |-> ($past(rd_n) && !$past(rd_n, 2) && !$past(cs_n)));

    p_acq_time_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> (trk_cnt >= ACQ_CYC));

    p_sel_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> $stable(in_sel_b));
endmodule

bind simsamp_seq simsamp_seq_chk #(
    .CONV_CYC(CONV_CYC),
    .ACQ_CYC (ACQ_CYC),
    .LW      (LW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .int_n     (int_n),
    .in_sel_b  (in_sel_b),
    .conv_lane (conv_lane),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .lanes_last(cfg_last_q)
);

// File: tb/tb_simsamp_seq.sv
`timescale 1ns/1ps
module tb_simsamp_seq;
    localparam int CONV = 3000 / 8;
    localparam int ACQ  = 1000 / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_last = 2'd0;
    logic        cfg_sel_b = 1'b0;
    logic        conv_start = 1'b0;
    logic [13:0] conv_data;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        hold, in_sel_b, int_n;
    logic [1:0]  conv_lane;
    logic [13:0] dout;

    int pass_cnt = 0;
    int fail_cnt = 0;
    int tag = 1;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    simsamp_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_last(cfg_last),
        .cfg_sel_b(cfg_sel_b), .conv_start(conv_start), .conv_data(conv_data),
        .cs_n(cs_n), .rd_n(rd_n), .hold(hold), .in_sel_b(in_sel_b),
        .conv_lane(conv_lane), .int_n(int_n), .dout(dout)
    );

    function automatic logic [13:0] word_of(int t, int lane, int selb);
        return 14'((t * 523 + lane * 97 + selb * 4099 + 1) % 16384);
    endfunction

    assign conv_data = word_of(tag, int'(conv_lane), int'(in_sel_b));

    task automatic chk(bit ok, string req, int act, int exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe();
        rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic configure(int n, int selb);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_last = 2'(n - 1);
        cfg_sel_b = selb[0];
        @(negedge clk);
        cfg_we = 1'b0;
        chk(in_sel_b == selb[0], "R11 select loaded", int'(in_sel_b), selb);
    endtask

    task automatic run_seq(int n, int selb);
        int k = 0;
        int lane_err = 0;
        int sel_err = 0;
        int early = 0;
        @(negedge clk);
        conv_start = 1'b1;
        @(negedge clk);
        chk(hold == 1'b1, "R2 hold one cycle after start", int'(hold), 1);
        while (hold && k < 5000) begin
            if (int'(conv_lane) != k / CONV) lane_err++;
            if (in_sel_b != selb[0]) sel_err++;
            if (k == 10) conv_start = 1'b0;
            if (k == 20) conv_start = 1'b1;
            if (k == 30) conv_start = 1'b0;
            if (k == 40) begin
                cfg_we = 1'b1;
                cfg_last = 2'(4 - n);
                cfg_sel_b = ~selb[0];
            end
            if (k == 41) cfg_we = 1'b0;
            k++;
            @(negedge clk);
        end
        chk(k == n * CONV, "R2 R3 hold length", k, n * CONV);
        chk(lane_err == 0, "R4 lane order", lane_err, 0);
        chk(sel_err == 0, "R11 select frozen in conversion", sel_err, 0);
        chk(int_n == 1'b0, "R5 int_n low at end", int'(int_n), 0);
        // R10: start edge right after the lanes return to tracking
        conv_start = 1'b1;
        for (int i = 0; i < ACQ + 10; i++) begin
            @(negedge clk);
            if (hold) early++;
        end
        conv_start = 1'b0;
        chk(early == 0, "R10 early start ignored", early, 0);
        chk(in_sel_b == selb[0], "R11 write during conversion ignored", int'(in_sel_b), selb);
        // readout
        cs_n = 1'b0;
        #1;
        chk(dout == word_of(tag, 0, selb), "R6 R12 first word is lane 0", int'(dout), int'(word_of(tag, 0, selb)));
        rd_n = 1'b0;
        @(negedge clk);
        chk(int_n == 1'b0, "R9 int_n held until strobe", int'(int_n), 0);
        rd_n = 1'b1;
        @(negedge clk);
        chk(int_n == 1'b1, "R9 int_n released by strobe", int'(int_n), 1);
        chk(dout == word_of(tag, 1 % n, selb), "R6 second word", int'(dout), int'(word_of(tag, 1 % n, selb)));
        for (int i = 1; i <= 2 * n; i++) begin
            strobe();
            chk(dout == word_of(tag, (i + 1) % n, selb), "R7 wrapping order", int'(dout),
                int'(word_of(tag, (i + 1) % n, selb)));
        end
        cs_n = 1'b1;
        #1;
        chk(dout == 14'd0, "R6 deselected output", int'(dout), 0);
        strobe();
        cs_n = 1'b0;
        #1;
        chk(dout == word_of(tag, (2 * n + 1) % n, selb), "R8 deselected strobe ignored", int'(dout),
            int'(word_of(tag, (2 * n + 1) % n, selb)));
        tag++;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cs_n = 1'b0;
        #1;
        chk(hold == 1'b0, "R1 reset hold", int'(hold), 0);
        chk(int_n == 1'b1, "R1 reset int_n", int'(int_n), 1);
        chk(in_sel_b == 1'b0, "R1 reset select", int'(in_sel_b), 0);
        chk(dout == 14'd0, "R1 reset buffer", int'(dout), 0);
        cs_n = 1'b1;
        repeat (ACQ + 5) @(negedge clk);
        run_seq(4, 0);      // R1 default of four lanes
        for (int s = 0; s < 2; s++) begin
            for (int n = 1; n <= 4; n++) begin
                configure(n, s);
                run_seq(n, s);
            end
        end
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fail_cnt++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
            $finish;
        end
    end
endmodule